// File: doc/BRIEF.md
# Quadrature Stepped-Sine Twisted-Ring Generator

This block divides its clock with a twisted-ring (Johnson) counter and turns the ring's tap bits into two stepped approximations of a sine wave that are locked 90 degrees apart. Each enabled clock moves the ring one step. It repeats every `2*RING_LEN` enabled clocks, and with the default four-stage ring one output cycle is eight clocks.

The in-phase channel I is a weighted sum of the ring taps. The quadrature channel Q applies the same weights to a window of taps that sits half a ring later. By default that window runs into follow-on stages that extend the chain, and each follow-on stage is a delayed copy of the ring. A parameter can instead build the upper half of the Q window from inverted early taps. In that variant no extension stages are built.

The outer taps weigh 5 and the inner taps weigh 12, so the largest steps fall at mid-swing. Both codes are registered on the same edge as the ring, so every output comes straight from a flop. The codes drive an external summing and filtering stage, which is outside this block. The first ring tap and the tap half a ring further on serve as 50 percent quadrature square waves.

Top module: `qsine_gen`

## Requirements
- R1: A clock edge with `rst` high clears every tap, both square waves and both codes to 0. `rst` takes priority over `en`.
- R2: On each edge with `en` high and `rst` low, tap 0 takes the inverse of tap 3 and tap k (k = 1..3) takes the old tap k-1. Starting from reset, taps[3:0] step through 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and then repeat with period 8.
- R3: While `en` is low, taps, square waves and both codes keep their values.
- R4: `code_i` equals 5*tap0 + 12*tap1 + 12*tap2 + 5*tap3 for the taps shown in the same cycle. It never exceeds 34.
- R5: Counting enabled edges from reset, `code_i` runs 0, 5, 17, 29, 34, 29, 17, 5 and then repeats.
- R6: With the default extended-chain variant (`QUAD_MODE` = QUAD_EXTEND), `code_q` equals the value `code_i` had two enabled edges earlier. Before the second enabled edge after reset it is 0.
- R7: `sq_i` equals tap 0 and `sq_q` equals tap 2. Each is high for 4 of every 8 enabled steps, and `sq_q` repeats `sq_i` two enabled steps later.
- R8: With the inverted-tap variant (`QUAD_MODE` = QUAD_INVERT), `code_q` equals 5*tap2 + 12*tap3 + 12*(1-tap0) + 5*(1-tap1) after the first enabled edge, and it is 0 in reset. From the second enabled edge after reset it matches the extended-chain variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; low holds all state |
| taps | output | RING_LEN (4) | Ring flop outputs, bit k is tap k |
| sq_i | output | 1 | In-phase square wave (tap 0) |
| sq_q | output | 1 | Quadrature square wave (tap RING_LEN/2) |
| code_i | output | CODE_W (6) | In-phase weighted step code |
| code_q | output | CODE_W (6) | Quadrature weighted step code |

## Verification
Every output is a single register stage deep. Taps, square waves and both codes therefore take their new values at the rising edge that samples `en` or `rst`. The bench drives inputs at the falling edge and reads outputs at the next falling edge, so each result is observed exactly one enabled edge after its stimulus. The quadrature lag is counted in enabled edges, not in clocks. The bench's model advances its step count only on edges where `en` was high, and it compares `code_q` against the model's I value from two enabled steps back. Hold windows, irregular enable patterns and a mid-run reset all exercise that counting.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

    // Source of the upper half of the quadrature tap window.
    typedef enum logic {
        QUAD_EXTEND = 1'b0,  // follow-on stages continue the chain
        QUAD_INVERT = 1'b1   // inverted early ring taps stand in for them
    } quad_mode_e;

    // Weight of tap idx in a window of len taps: the two ends carry the
    // outer weight, everything between them the inner weight.
    function automatic int tap_weight(int idx, int len, int w_out, int w_in);
        if (idx == 0 || idx == len - 1) begin
            return w_out;
        end
        return w_in;
    endfunction

endpackage

// File: rtl/qsine_ring.sv
module qsine_ring
    import qsine_pkg::*;
#(
    parameter int         RING_LEN  = 4,
    parameter quad_mode_e QUAD_MODE = QUAD_EXTEND
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    output logic [RING_LEN-1:0]      ring_q,
    output logic [RING_LEN-1:0]      ring_d,
    output logic [RING_LEN/2-1:0]    ext_d
);
    localparam int HALF = RING_LEN / 2;

    typedef struct packed {
        logic [RING_LEN-1:0] ring;
        logic [HALF-1:0]     ext;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (en) begin
            st_d.ring = {st_q.ring[RING_LEN-2:0], ~st_q.ring[RING_LEN-1]};
            if (QUAD_MODE == QUAD_EXTEND) begin
                st_d.ext = {st_q.ext[HALF-2:0], st_q.ring[RING_LEN-1]};
            end else begin
                st_d.ext = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ring_q = st_q.ring;
    assign ring_d = st_d.ring;
    assign ext_d  = st_d.ext;

endmodule

// File: rtl/qsine_wsum.sv
module qsine_wsum
    import qsine_pkg::*;
#(
    parameter int WIN     = 4,
    parameter int W_OUTER = 5,
    parameter int W_INNER = 12,
    parameter int CODE_W  = 6
) (
    input  logic [WIN-1:0]    bits_i,
    output logic [CODE_W-1:0] sum_o
);
    int acc;

    always_comb begin
        acc = 0;
        for (int k = 0; k < WIN; k++) begin
            if (bits_i[k]) begin
                acc = acc + tap_weight(k, WIN, W_OUTER, W_INNER);
            end
        end
        sum_o = CODE_W'(acc);
    end

endmodule

// File: rtl/qsine_gen.sv
module qsine_gen
    import qsine_pkg::*;
#(
    parameter int         RING_LEN  = 4,
    parameter int         W_OUTER   = 5,
    parameter int         W_INNER   = 12,
    parameter quad_mode_e QUAD_MODE = QUAD_EXTEND,
    parameter int         CODE_W    = $clog2(2 * W_OUTER + (RING_LEN - 2) * W_INNER + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [RING_LEN-1:0] taps,
    output logic                sq_i,
    output logic                sq_q,
    output logic [CODE_W-1:0]   code_i,
    output logic [CODE_W-1:0]   code_q
);
    localparam int HALF = RING_LEN / 2;

    typedef struct packed {
        logic [CODE_W-1:0] ci;
        logic [CODE_W-1:0] cq;
    } code_t;

    logic [RING_LEN-1:0] ring_q, ring_d;
    logic [HALF-1:0]     ext_d;
    logic [RING_LEN-1:0] qbits_d;
    logic [CODE_W-1:0]   sum_i, sum_q;
    code_t               code_d, code_r;

    qsine_ring #(
        .RING_LEN  (RING_LEN),
        .QUAD_MODE (QUAD_MODE)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ring_q (ring_q),
        .ring_d (ring_d),
        .ext_d  (ext_d)
    );

    // Quadrature window: upper half of the ring, then either the
    // extension stages or the inverted lower half of the ring.
    for (genvar j = 0; j < HALF; j++) begin : g_qlow
        assign qbits_d[j] = ring_d[j + HALF];
    end

    if (QUAD_MODE == QUAD_EXTEND) begin : g_qext
        for (genvar j = 0; j < HALF; j++) begin : g_bit
            assign qbits_d[j + HALF] = ext_d[j];
        end
    end else begin : g_qinv
        for (genvar j = 0; j < HALF; j++) begin : g_bit
            assign qbits_d[j + HALF] = ~ring_d[j];
        end
    end

    qsine_wsum #(
        .WIN     (RING_LEN),
        .W_OUTER (W_OUTER),
        .W_INNER (W_INNER),
        .CODE_W  (CODE_W)
    ) u_sum_i (
        .bits_i (ring_d),
        .sum_o  (sum_i)
    );

    qsine_wsum #(
        .WIN     (RING_LEN),
        .W_OUTER (W_OUTER),
        .W_INNER (W_INNER),
        .CODE_W  (CODE_W)
    ) u_sum_q (
        .bits_i (qbits_d),
        .sum_o  (sum_q)
    );

    always_comb begin
        code_d = code_r;
        if (rst) begin
            code_d = '0;
        end else if (en) begin
            code_d.ci = sum_i;
            code_d.cq = sum_q;
        end
    end

    always_ff @(posedge clk) begin
        code_r <= code_d;
    end

    assign taps   = ring_q;
    assign sq_i   = ring_q[0];
    assign sq_q   = ring_q[HALF];
    assign code_i = code_r.ci;
    assign code_q = code_r.cq;

endmodule

// File: rtl/qsine_gen_chk.sv
module qsine_gen_chk
    import qsine_pkg::*;
#(
    parameter int         RING_LEN  = 4,
    parameter int         W_OUTER   = 5,
    parameter int         W_INNER   = 12,
    parameter quad_mode_e QUAD_MODE = QUAD_EXTEND,
    parameter int         CODE_W    = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [RING_LEN-1:0] taps,
    input logic                sq_i,
    input logic                sq_q,
    input logic [CODE_W-1:0]   code_i,
    input logic [CODE_W-1:0]   code_q
);
    localparam int HALF     = RING_LEN / 2;
    localparam int MAX_CODE = 2 * W_OUTER + (RING_LEN - 2) * W_INNER;

    logic [CODE_W-1:0] hist [HALF];
    int                exp_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < HALF; k++) hist[k] <= '0;
        end else if (en) begin
            hist[0] <= code_i;
            for (int k = 1; k < HALF; k++) hist[k] <= hist[k-1];
        end
    end

    always_comb begin
        exp_i = 0;
        for (int k = 0; k < RING_LEN; k++) begin
            if (taps[k]) exp_i = exp_i + tap_weight(k, RING_LEN, W_OUTER, W_INNER);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (taps == '0 && code_i == '0 && code_q == '0 && !sq_i && !sq_q));

    p_twist_step_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> taps == {$past(taps[RING_LEN-2:0]), ~$past(taps[RING_LEN-1])});

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(taps) && $stable(code_i) && $stable(code_q)));

    p_weight_r4: assert property (@(posedge clk) disable iff (rst)
        (int'(code_i) == exp_i) && (int'(code_i) <= MAX_CODE));

    p_sq_lag_r7: assert property (@(posedge clk) disable iff (rst)
        en |=> sq_q == $past(taps[HALF-1]));

    if (QUAD_MODE == QUAD_EXTEND) begin : g_lag
        p_quad_lag_r6: assert property (@(posedge clk) disable iff (rst)
            code_q == hist[HALF-1]);
    end

endmodule

bind qsine_gen qsine_gen_chk #(
    .RING_LEN  (RING_LEN),
    .W_OUTER   (W_OUTER),
    .W_INNER   (W_INNER),
    .QUAD_MODE (QUAD_MODE),
    .CODE_W    (CODE_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .taps   (taps),
    .sq_i   (sq_i),
    .sq_q   (sq_q),
    .code_i (code_i),
    .code_q (code_q)
);

// File: tb/tb_qsine_gen.sv
module tb_qsine_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;

    logic [3:0] taps, taps_v;
    logic       sq_i, sq_q, sq_i_v, sq_q_v;
    logic [5:0] code_i, code_q, code_i_v, code_q_v;

    int vectors = 0;
    int fails   = 0;
    int k       = 0;   // enabled edges since reset
    bit done    = 0;

    always #5 clk = ~clk;

    qsine_gen dut (
        .clk(clk), .rst(rst), .en(en), .taps(taps), .sq_i(sq_i),
        .sq_q(sq_q), .code_i(code_i), .code_q(code_q)
    );

    qsine_gen #(.QUAD_MODE(qsine_pkg::QUAD_INVERT)) dut_inv (
        .clk(clk), .rst(rst), .en(en), .taps(taps_v), .sq_i(sq_i_v),
        .sq_q(sq_q_v), .code_i(code_i_v), .code_q(code_q_v)
    );

    function automatic bit ebit(int n, int j);
        int p = n % 8;
        return (p > j) && (p <= j + 4);
    endfunction

    function automatic int ecode(int n);
        if (n < 0) return 0;
        return 5 * ebit(n, 0) + 12 * ebit(n, 1) + 12 * ebit(n, 2) + 5 * ebit(n, 3);
    endfunction

    function automatic int einv(int n);
        if (n == 0) return 0;
        return 5 * ebit(n, 2) + 12 * ebit(n, 3) + 12 * !ebit(n, 0) + 5 * !ebit(n, 1);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (step %0d)", tag, what, act, exp, k);
        end
    endtask

    task automatic check_all(string tag);
        int ring_exp = 0;
        int seq [8] = '{0, 5, 17, 29, 34, 29, 17, 5};
        for (int j = 0; j < 4; j++) ring_exp |= int'(ebit(k, j)) << j;
        chk({tag, "/R2"}, "taps", int'(taps), ring_exp);
        chk({tag, "/R4"}, "code_i", int'(code_i), ecode(k));
        chk({tag, "/R5"}, "code_i seq", int'(code_i), seq[k % 8]);
        chk({tag, "/R6"}, "code_q", int'(code_q), ecode(k - 2));
        chk({tag, "/R7"}, "sq_i", int'(sq_i), int'(ebit(k, 0)));
        chk({tag, "/R7"}, "sq_q", int'(sq_q), int'(ebit(k - 2 < 0 ? 0 : k - 2, 0)));
        chk({tag, "/R8"}, "inv code_q", int'(code_q_v), einv(k));
        if (k >= 2) chk({tag, "/R8"}, "inv vs ext", int'(code_q_v), int'(code_q));
        chk({tag, "/R8"}, "inv taps", int'(taps_v), ring_exp);
    endtask

    // one edge: inputs already set at a falling edge; read at the next one
    task automatic edge_step(string tag);
        bit stepped = en && !rst;
        bit cleared = rst;
        @(posedge clk);
        @(negedge clk);
        if (cleared) k = 0;
        else if (stepped) k++;
        check_all(tag);
    endtask

    initial begin
        @(negedge clk);
        edge_step("R1");
        edge_step("R1");
        chk("R1", "code_q reset", int'(code_q), 0);
        chk("R1", "inv code_q reset", int'(code_q_v), 0);
        rst = 1'b0;
        en  = 1'b1;
        for (int n = 0; n < 20; n++) edge_step("R2");
        en = 1'b0;
        for (int n = 0; n < 3; n++) edge_step("R3");
        for (int n = 0; n < 60; n++) begin
            en = ((n * 7) % 5) < 3;
            edge_step(en ? "R6" : "R3");
        end
        en  = 1'b1;
        rst = 1'b1;
        edge_step("R1");
        chk("R1", "sq_q after mid reset", int'(sq_q), 0);
        rst = 1'b0;
        for (int n = 0; n < 12; n++) edge_step("R5");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule